// File: doc/BRIEF.md
# Barrel Shift Unit with Condition Flags

This block is the shift stage of a processor datapath. A 32-bit source operand goes in, and the block produces a 32-bit shifted result on its own output. The source operand is never changed. Five operations are available: arithmetic right, logical left, logical right, rotate right, and a one-place rotate through the carry flag. The shift count comes from one of two places. It is either a small immediate field with a separate legal window for each operation, or the low byte of a register value, which gives counts from 0 to 255.

Alongside the result, the block computes the negative, zero and carry flags. These are updated only when the flag-update input is set. Otherwise the incoming flag values pass straight through. The shift logic itself is combinational. One register stage holds the result, the flags and an illegal-count indication, so a request applied in one cycle is visible on the outputs after the next rising clock edge.

Top module: `shift_flags_unit`

## Requirements
- R1: `op_i` encodes the operation: 0 = arithmetic right, 1 = logical left, 2 = logical right, 3 = rotate right, 4 = rotate right through carry. For counts 1 to 31, the result is the operand shifted or rotated by that count. Arithmetic right copies bit 31 into the vacated bits, and the logical shifts fill them with zeros.
- R2: When `amt_from_reg_i` is 1, the count is `amt_reg_i[7:0]`. Bits 31:8 of `amt_reg_i` have no effect on any output.
- R3: When `amt_from_reg_i` is 0, the count is `amt_imm_i` (6 bits). It is legal only within these windows: 1..32 for arithmetic right, 0..31 for logical left, 1..32 for logical right, 1..31 for rotate right. Codes 5 to 7 are illegal in both forms. An illegal request sets `illegal_o`, returns the operand unchanged, and passes all three flags through from their inputs.
- R4: Rotate right through carry gives `{carry_i, operand_i[31:1]}` whatever the count inputs hold. Its carry-out is `operand_i[0]`.
- R5: For a register count of 32 or more, the logical shifts give zero and arithmetic right gives 32 copies of bit 31. At exactly 32, the carry-out is bit 0 (logical left) or bit 31 (the right shifts). Above 32, the logical shifts give a carry-out of 0 and arithmetic right gives bit 31.
- R6: Rotate right uses the count modulo 32. A nonzero count that is a multiple of 32 returns the operand unchanged, with carry-out equal to its bit 31.
- R7: A count of zero in any shift or rotate form returns the operand unchanged and keeps the carry at `carry_i`. An immediate logical left by 0 therefore acts as a plain move.
- R8: With `flag_upd_i` set on a legal request, `neg_o` equals bit 31 of the result and `zero_o` is 1 exactly when the result is zero.
- R9: With `flag_upd_i` set and a nonzero count, `carry_o` is the last bit shifted out. For rotate right, this is bit 31 of the result.
- R10: With `flag_upd_i` clear, `neg_o`, `zero_o` and `carry_o` equal `neg_i`, `zero_i` and `carry_i`.
- R11: All outputs are registered and appear after one rising edge of `clk_i`. While `rst_ni` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_i | input | 3 | Operation code |
| amt_from_reg_i | input | 1 | 1: count from register low byte; 0: from immediate |
| amt_imm_i | input | 6 | Immediate shift count |
| amt_reg_i | input | 32 | Register value whose low byte is the count |
| operand_i | input | 32 | Value to shift |
| carry_i | input | 1 | Current carry flag |
| neg_i | input | 1 | Current negative flag |
| zero_i | input | 1 | Current zero flag |
| flag_upd_i | input | 1 | Enables the flag update |
| result_o | output | 32 | Shifted result |
| neg_o | output | 1 | Negative flag out |
| zero_o | output | 1 | Zero flag out |
| carry_o | output | 1 | Carry flag out |
| illegal_o | output | 1 | Immediate count or code out of range |

## Verification
Every output of this block is due exactly one rising edge after its request is applied. This holds for the result, all three flags and the illegal indication alike, because a single register stage sits behind the combinational shifter. The bench changes inputs on the falling edge and reads the outputs on the following falling edge, so exactly one capturing edge lies between stimulus and sample. The in-design properties compare each output against the input sampled one cycle earlier.

// File: rtl/shf_pkg.sv
package shf_pkg;

    typedef enum logic [2:0] {
        OP_ASR = 3'd0,
        OP_LSL = 3'd1,
        OP_LSR = 3'd2,
        OP_ROR = 3'd3,
        OP_RRX = 3'd4
    } shf_op_e;

    localparam int AMT_W = 8;

endpackage

// File: rtl/shf_amount.sv
module shf_amount
    import shf_pkg::*;
#(
    parameter int WIDTH = 32,
    localparam int IMM_W = $clog2(WIDTH) + 1
) (
    input  logic [2:0]       op_i,
    input  logic             from_reg_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic [WIDTH-1:0] reg_i,
    output logic [AMT_W-1:0] amt_o,
    output logic             illegal_o
);
    localparam logic [IMM_W-1:0] IMM_FULL = IMM_W'(WIDTH);
    localparam logic [IMM_W-1:0] IMM_ZERO = '0;

    always_comb begin
        amt_o     = from_reg_i ? reg_i[AMT_W-1:0] : AMT_W'(imm_i);
        illegal_o = 1'b0;
        case (op_i)
            OP_ASR, OP_LSR: illegal_o = !from_reg_i && (imm_i == IMM_ZERO || imm_i > IMM_FULL);
            OP_LSL:         illegal_o = !from_reg_i && (imm_i >= IMM_FULL);
            OP_ROR:         illegal_o = !from_reg_i && (imm_i == IMM_ZERO || imm_i >= IMM_FULL);
            OP_RRX:         illegal_o = 1'b0;
            default:        illegal_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/shf_core.sv
module shf_core
    import shf_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [2:0]       op_i,
    input  logic [AMT_W-1:0] amt_i,
    input  logic [WIDTH-1:0] operand_i,
    input  logic             carry_i,
    output logic [WIDTH-1:0] result_o,
    output logic             carry_o
);
    localparam int SHW = $clog2(WIDTH);
    localparam logic [AMT_W-1:0] FULL = AMT_W'(WIDTH);

    logic [WIDTH-1:0]   probe;
    logic [2*WIDTH-1:0] dbl;
    logic [SHW-1:0]     rot;

    always_comb begin
        result_o = operand_i;
        carry_o  = carry_i;
        probe    = '0;
        dbl      = '0;
        rot      = amt_i[SHW-1:0];
        case (op_i)
            OP_ASR: begin
                if (amt_i >= FULL) begin
                    result_o = {WIDTH{operand_i[WIDTH-1]}};
                    carry_o  = operand_i[WIDTH-1];
                end else if (amt_i != '0) begin
                    result_o = WIDTH'($signed(operand_i) >>> amt_i);
                    probe    = operand_i >> (amt_i - AMT_W'(1));
                    carry_o  = probe[0];
                end
            end
            OP_LSL: begin
                if (amt_i > FULL) begin
                    result_o = '0;
                    carry_o  = 1'b0;
                end else if (amt_i == FULL) begin
                    result_o = '0;
                    carry_o  = operand_i[0];
                end else if (amt_i != '0) begin
                    result_o = operand_i << amt_i;
                    probe    = operand_i >> (FULL - amt_i);
                    carry_o  = probe[0];
                end
            end
            OP_LSR: begin
                if (amt_i > FULL) begin
                    result_o = '0;
                    carry_o  = 1'b0;
                end else if (amt_i == FULL) begin
                    result_o = '0;
                    carry_o  = operand_i[WIDTH-1];
                end else if (amt_i != '0) begin
                    result_o = operand_i >> amt_i;
                    probe    = operand_i >> (amt_i - AMT_W'(1));
                    carry_o  = probe[0];
                end
            end
            OP_ROR: begin
                if (amt_i != '0) begin
                    dbl      = {operand_i, operand_i} >> rot;
                    result_o = dbl[WIDTH-1:0];
                    carry_o  = dbl[WIDTH-1];
                end
            end
            OP_RRX: begin
                result_o = {carry_i, operand_i[WIDTH-1:1]};
                carry_o  = operand_i[0];
            end
            default: begin
                result_o = operand_i;
                carry_o  = carry_i;
            end
        endcase
    end
endmodule

// File: rtl/shift_flags_unit.sv
module shift_flags_unit
    import shf_pkg::*;
#(
    parameter int WIDTH = 32,
    localparam int IMM_W = $clog2(WIDTH) + 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [2:0]       op_i,
    input  logic             amt_from_reg_i,
    input  logic [IMM_W-1:0] amt_imm_i,
    input  logic [WIDTH-1:0] amt_reg_i,
    input  logic [WIDTH-1:0] operand_i,
    input  logic             carry_i,
    input  logic             neg_i,
    input  logic             zero_i,
    input  logic             flag_upd_i,
    output logic [WIDTH-1:0] result_o,
    output logic             neg_o,
    output logic             zero_o,
    output logic             carry_o,
    output logic             illegal_o
);
    typedef struct packed {
        logic [WIDTH-1:0] result;
        logic             neg;
        logic             zero;
        logic             carry;
        logic             illegal;
    } out_t;

    out_t state_d, state_q;

    logic [AMT_W-1:0] amt;
    logic             bad_amt;
    logic [WIDTH-1:0] core_res;
    logic             core_carry;

    shf_amount #(.WIDTH(WIDTH)) amount_i (
        .op_i       (op_i),
        .from_reg_i (amt_from_reg_i),
        .imm_i      (amt_imm_i),
        .reg_i      (amt_reg_i),
        .amt_o      (amt),
        .illegal_o  (bad_amt)
    );

    shf_core #(.WIDTH(WIDTH)) core_i (
        .op_i      (op_i),
        .amt_i     (amt),
        .operand_i (operand_i),
        .carry_i   (carry_i),
        .result_o  (core_res),
        .carry_o   (core_carry)
    );

    always_comb begin
        state_d.illegal = bad_amt;
        state_d.result  = bad_amt ? operand_i : core_res;
        if (flag_upd_i && !bad_amt) begin
            state_d.neg   = core_res[WIDTH-1];
            state_d.zero  = (core_res == '0);
            state_d.carry = core_carry;
        end else begin
            state_d.neg   = neg_i;
            state_d.zero  = zero_i;
            state_d.carry = carry_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= '0;
        else         state_q <= state_d;
    end

    assign result_o  = state_q.result;
    assign neg_o     = state_q.neg;
    assign zero_o    = state_q.zero;
    assign carry_o   = state_q.carry;
    assign illegal_o = state_q.illegal;

    assert_flags_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !flag_upd_i |=> (neg_o == $past(neg_i)) && (zero_o == $past(zero_i)) && (carry_o == $past(carry_i)));

    assert_zero_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag_upd_i && !bad_amt) |=> zero_o == (result_o == '0));

    assert_neg_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag_upd_i && !bad_amt) |=> neg_o == result_o[WIDTH-1]);

    assert_illegal_pass_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bad_amt |=> illegal_o && (result_o == $past(operand_i)) && (carry_o == $past(carry_i)));

    assert_rrx_fill_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == OP_RRX) |=> result_o[WIDTH-1] == $past(carry_i));

    assert_zero_amt_carry_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == OP_LSL && !amt_from_reg_i && amt_imm_i == '0)
            |=> (result_o == $past(operand_i)) && (carry_o == $past(carry_i)));
endmodule

// File: tb/shift_flags_unit_tb_top.sv
module shift_flags_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op = '0;
    logic        from_reg = 1'b0;
    logic [5:0]  imm = '0;
    logic [31:0] regv = '0;
    logic [31:0] opnd = '0;
    logic        cin = 1'b0, nin = 1'b0, zin = 1'b0, upd = 1'b0;
    logic [31:0] res;
    logic        nout, zout, cout, ill;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    shift_flags_unit dut_i (
        .clk_i(clk), .rst_ni(rst_n), .op_i(op), .amt_from_reg_i(from_reg),
        .amt_imm_i(imm), .amt_reg_i(regv), .operand_i(opnd), .carry_i(cin),
        .neg_i(nin), .zero_i(zin), .flag_upd_i(upd),
        .result_o(res), .neg_o(nout), .zero_o(zout), .carry_o(cout), .illegal_o(ill)
    );

    typedef struct packed {
        logic [2:0]  op;
        logic        src;
        logic [5:0]  imm;
        logic [31:0] regv;
        logic [31:0] opnd;
        logic        c, n, z, upd;
        logic [31:0] eres;
        logic        en, ez, ec, eill;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{3'd1, 1'b0, 6'd4,  32'h0,        32'h0000_00F1, 0,0,0,1, 32'h0000_0F10, 0,0,0,0}, // R1 LSL
        '{3'd2, 1'b0, 6'd1,  32'h0,        32'h0000_0003, 0,0,0,1, 32'h0000_0001, 0,0,1,0}, // R9 LSR
        '{3'd0, 1'b0, 6'd32, 32'h0,        32'h8000_0000, 0,0,0,1, 32'hFFFF_FFFF, 1,0,1,0}, // R3 ASR #32
        '{3'd3, 1'b0, 6'd8,  32'h0,        32'h1234_5678, 1,0,0,1, 32'h7812_3456, 0,0,0,0}, // R1 ROR
        '{3'd4, 1'b0, 6'd9,  32'h0,        32'h0000_0001, 1,0,0,1, 32'h8000_0000, 1,0,1,0}, // R4 RRX
        '{3'd1, 1'b0, 6'd0,  32'h0,        32'hDEAD_BEEF, 1,0,0,1, 32'hDEAD_BEEF, 1,0,1,0}, // R7 move
        '{3'd1, 1'b0, 6'd32, 32'h0,        32'h0000_0001, 0,0,0,1, 32'h0000_0001, 0,0,0,1}, // R3 LSL #32
        '{3'd3, 1'b0, 6'd0,  32'h0,        32'h0000_0005, 1,0,1,1, 32'h0000_0005, 0,1,1,1}, // R3 ROR #0
        '{3'd2, 1'b1, 6'd0,  32'hFFFF_FF21, 32'hFFFF_FFFF, 1,0,0,1, 32'h0,        0,1,0,0}, // R5 LSR 33
        '{3'd1, 1'b1, 6'd0,  32'h0000_0100, 32'h8000_0000, 0,0,0,1, 32'h8000_0000, 1,0,0,0}, // R2 low byte 0
        '{3'd1, 1'b1, 6'd0,  32'h0000_0020, 32'h0000_0001, 0,0,0,1, 32'h0,        0,1,1,0}, // R5 LSL 32
        '{3'd2, 1'b0, 6'd4,  32'h0,        32'h0000_00F0, 0,1,1,0, 32'h0000_000F, 1,1,0,0}, // R10 no update
        '{3'd3, 1'b1, 6'd0,  32'h0000_0040, 32'h8000_0001, 0,0,0,1, 32'h8000_0001, 1,0,1,0}  // R6 ROR 64
    };

    // Independent model: one-place steps repeated count times.
    function automatic void model(input logic [2:0] o, input int unsigned cnt,
                                  input logic [31:0] v, input logic c,
                                  output logic [31:0] r, output logic co);
        r = v; co = c;
        if (o == 3'd4) begin
            co = v[0]; r = {c, v[31:1]};
            return;
        end
        for (int i = 0; i < cnt; i++) begin
            case (o)
                3'd0: begin co = r[0];  r = {r[31], r[31:1]}; end
                3'd1: begin co = r[31]; r = {r[30:0], 1'b0}; end
                3'd2: begin co = r[0];  r = {1'b0, r[31:1]}; end
                default: begin r = {r[0], r[31:1]}; co = r[31]; end
            endcase
        end
    endfunction

    task automatic check(input string req, input logic [31:0] er, input logic en,
                         input logic ez, input logic ec, input logic eil);
        n_checks++;
        if (res !== er || nout !== en || zout !== ez || cout !== ec || ill !== eil) begin
            n_fail++;
            $display("FAIL %s: got res=%h n=%b z=%b c=%b ill=%b, expected res=%h n=%b z=%b c=%b ill=%b",
                     req, res, nout, zout, cout, ill, er, en, ez, ec, eil);
        end
    endtask

    task automatic apply(input logic [2:0] o, input logic s, input logic [5:0] im,
                         input logic [31:0] rv, input logic [31:0] d,
                         input logic c, input logic n, input logic z, input logic u);
        @(negedge clk);
        op = o; from_reg = s; imm = im; regv = rv; opnd = d;
        cin = c; nin = n; zin = z; upd = u;
        @(negedge clk);
    endtask

    initial begin
        #(5.0 * 150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [31:0] er;
        logic ec;
        int unsigned amts [6] = '{0, 1, 31, 32, 33, 255};
        repeat (3) @(negedge clk);
        check("R11 reset", 32'h0, 0, 0, 0, 0);
        rst_n = 1'b1;

        for (int k = 0; k < NV; k++) begin
            apply(VECS[k].op, VECS[k].src, VECS[k].imm, VECS[k].regv, VECS[k].opnd,
                  VECS[k].c, VECS[k].n, VECS[k].z, VECS[k].upd);
            check($sformatf("table[%0d] R1/R3/R5/R9", k), VECS[k].eres, VECS[k].en,
                  VECS[k].ez, VECS[k].ec, VECS[k].eill);
        end

        // R2: upper register bits ignored; R5/R6 large counts against the model.
        for (int it = 0; it < 40; it++) begin
            for (int o = 0; o < 5; o++) begin
                for (int a = 0; a < 6; a++) begin
                    logic [31:0] d;
                    logic c;
                    d = $urandom(); c = 1'($urandom());
                    model(3'(o), amts[a], d, c, er, ec);
                    apply(3'(o), 1'b1, 6'($urandom()), {24'($urandom()), 8'(amts[a])}, d, c, 0, 0, 1);
                    check("R2 R5 R6 R9 model", er, er[31], er == 0, ec, 0);
                end
            end
        end

        // R1: random legal immediates 1..31, with flag update on.
        for (int it = 0; it < 200; it++) begin
            logic [31:0] d;
            int unsigned cnt;
            logic [2:0] o;
            d = $urandom(); cnt = 1 + ($urandom() % 31); o = 3'($urandom() % 4);
            model(o, cnt, d, 1'b0, er, ec);
            apply(o, 1'b0, 6'(cnt), 32'h0, d, 0, 0, 0, 1);
            check("R1 imm model", er, er[31], er == 0, ec, 0);
        end

        // R3: undefined code 6 is illegal.
        apply(3'd6, 1'b1, 6'd3, 32'd3, 32'h1357_9BDF, 1, 1, 0, 1);
        check("R3 bad code", 32'h1357_9BDF, 1, 0, 1, 1);
        // R3: LSR #32 legal, ROR #31 legal boundary.
        apply(3'd2, 1'b0, 6'd32, 32'h0, 32'h8000_0000, 0, 0, 0, 1);
        check("R3 LSR #32", 32'h0, 0, 1, 1, 0);
        apply(3'd3, 1'b0, 6'd31, 32'h0, 32'h0000_0001, 0, 0, 0, 1);
        check("R3 ROR #31", 32'h0000_0002, 0, 0, 0, 0);
        // R7: register count 0 on ASR keeps carry.
        apply(3'd0, 1'b1, 6'd0, 32'hFF00, 32'h8000_0000, 1, 0, 0, 1);
        check("R7 ASR by 0", 32'h8000_0000, 1, 0, 1, 0);
        // R11: reset mid-run clears outputs.
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check("R11 reset again", 32'h0, 0, 0, 0, 0);
        rst_n = 1'b1;

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        done = 1'b1;
        $finish;
    end
endmodule